// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block keeps the processor's live status word and a separate saved copy of it that belongs to the interrupt mode. When an instruction retires, it looks at a level-sensitive interrupt request. If the request is unmasked, it takes the interrupt. In one clock edge it stores the return address for the link register, saves the live status, sets the mask bit, switches the mode field to interrupt mode and steers fetch to a fixed vector. It also raises a one-cycle pipeline flush.

The block also spots the return instruction. This is a retiring data operation that sets flags and whose destination is the PC. When it sees one, it copies the saved status back into the live status. The datapath writes LR minus 4 into the PC for that same instruction, so the interrupted code resumes with its status unchanged. A retiring status-write instruction loads the live status directly. This is how software leaves the reset mode and unmasks interrupts. Decode, the ALU and the register file are outside this block.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset the live status is 0x00000093: mask bit 7 set, mode field bits 4..0 = 10011 (supervisor), all other bits 0. The saved status is 0, and the redirect, flush and link-write outputs are low.
- R2: An interrupt is taken when `retire_i` and `irq_i` are both 1, status bit 7 is 0, and the retiring instruction is not a return. In the cycle after that edge, `redirect_o`, `flush_o` and `lr_we_o` are 1 for exactly one cycle, and `redirect_pc_o` is 0x18.
- R3: On entry, `lr_wd_o` carries `next_pc_i` + 4, taken from the retiring cycle.
- R4: On entry, the saved status takes the live status the retiring instruction leaves behind.
- R5: On entry, the live status keeps all its bits except two changes: bit 7 becomes 1 and bits 4..0 become 10010 (interrupt mode).
- R6: `irq_i` has no effect on status or outputs in two cases: in a cycle where `retire_i` is 0, and in any cycle where status bit 7 is 1.
- R7: A retiring instruction with `is_dataop_i`, `sets_flags_i` and `dest_pc_i` all 1 is a return. It copies the saved status into the live status. The saved status is left unchanged and no redirect occurs.
- R8: When a return retires while `irq_i` is high, only the restore happens. The request is judged again at the next retire, using the restored mask bit.
- R9: A retiring instruction with `stat_we_i` = 1 (and not a return) loads `stat_wd_i` into the live status.
- R10: Entry followed by return gives back the exact live status that existed before entry, flag bits 31..28 included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Level-sensitive interrupt request |
| retire_i | input | 1 | An instruction retires this cycle |
| next_pc_i | input | AW | Address of the instruction after the retiring one |
| is_dataop_i | input | 1 | Retiring instruction is a data operation |
| sets_flags_i | input | 1 | Retiring instruction sets flags |
| dest_pc_i | input | 1 | Retiring instruction writes the PC |
| stat_we_i | input | 1 | Retiring instruction writes the live status |
| stat_wd_i | input | SW | Value for the status write |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | AW | Redirect target (fixed vector) |
| flush_o | output | 1 | One-cycle pipeline flush |
| lr_we_o | output | 1 | Link register write enable |
| lr_wd_o | output | AW | Link register write data |
| status_o | output | SW | Live status word |
| saved_o | output | SW | Saved status word |

## Verification
The bench sweeps every pattern of the four flag bits. Each pattern is combined with several return addresses, and each one runs a full entry–masked-retry–return sequence. Errors in the saved copy, the link-address offset, or the mask and mode rewrite each appear as a distinct miscompare. Requests that arrive without a retire, or while masked, separate the sampling rule from the mask rule. A return that retires together with a pending request shows whether the restore has priority and whether the request is taken at the following boundary.

// File: rtl/irq_entry_unit.sv
module irq_entry_unit #(
  parameter int AW = 32,
  parameter int SW = 32,
  parameter logic [AW-1:0] VECTOR = 'h18,
  parameter int LR_OFS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_i,
  input  logic          retire_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic          is_dataop_i,
  input  logic          sets_flags_i,
  input  logic          dest_pc_i,
  input  logic          stat_we_i,
  input  logic [SW-1:0] stat_wd_i,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic          flush_o,
  output logic          lr_we_o,
  output logic [AW-1:0] lr_wd_o,
  output logic [SW-1:0] status_o,
  output logic [SW-1:0] saved_o
);
  localparam int MASK_BIT = 7;
  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [SW-1:0] RESET_STAT = SW'({1'b1, 2'b00, MODE_SVC});

  logic [SW-1:0] stat_q, saved_q, eff, entered;
  logic [AW-1:0] lr_q;
  logic          pulse_q;

  wire is_return = retire_i & is_dataop_i & sets_flags_i & dest_pc_i;
  wire take = retire_i & irq_i & ~stat_q[MASK_BIT] & ~is_return;

  always_comb begin
    if (is_return)                 eff = saved_q;
    else if (retire_i & stat_we_i) eff = stat_wd_i;
    else                           eff = stat_q;
    entered = eff;
    entered[MASK_BIT] = 1'b1;
    entered[MODE_W-1:0] = MODE_IRQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= RESET_STAT;
      saved_q <= '0;
      lr_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= take;
      if (take) begin
        saved_q <= eff;
        stat_q  <= entered;
        lr_q    <= next_pc_i + AW'(LR_OFS);
      end else if (retire_i) begin
        stat_q  <= eff;
      end
    end
  end

  assign redirect_o    = pulse_q;
  assign flush_o       = pulse_q;
  assign lr_we_o       = pulse_q;
  assign redirect_pc_o = VECTOR;
  assign lr_wd_o       = lr_q;
  assign status_o      = stat_q;
  assign saved_o       = saved_q;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int AW = 32,
  parameter int SW = 32,
  parameter int LR_OFS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_i,
  input logic          retire_i,
  input logic [AW-1:0] next_pc_i,
  input logic          is_dataop_i,
  input logic          sets_flags_i,
  input logic          dest_pc_i,
  input logic          stat_we_i,
  input logic          redirect_o,
  input logic [AW-1:0] lr_wd_o,
  input logic [SW-1:0] status_o,
  input logic [SW-1:0] saved_o
);
  // R2
  entry_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o);
  // R5
  entry_mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (status_o[7] && status_o[4:0] == 5'b10010));
  // R3
  link_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> lr_wd_o == $past(next_pc_i) + AW'(LR_OFS));
  // R4
  saved_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !$past(stat_we_i)) |-> saved_o == $past(status_o));
  // R6
  no_entry_unretired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |=> !redirect_o);
  // R6
  no_entry_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] |=> !redirect_o);
  // R7
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && is_dataop_i && sets_flags_i && dest_pc_i) |=>
      (status_o == $past(saved_o) && saved_o == $past(saved_o) && !redirect_o));
  // R8
  restore_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && irq_i && is_dataop_i && sets_flags_i && dest_pc_i) |=> !redirect_o);
endmodule

bind irq_entry_unit irq_entry_chk #(.AW(AW), .SW(SW), .LR_OFS(LR_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .retire_i(retire_i),
  .next_pc_i(next_pc_i), .is_dataop_i(is_dataop_i), .sets_flags_i(sets_flags_i),
  .dest_pc_i(dest_pc_i), .stat_we_i(stat_we_i), .redirect_o(redirect_o),
  .lr_wd_o(lr_wd_o), .status_o(status_o), .saved_o(saved_o)
);

// File: tb/sim_irq_entry_unit.sv
`timescale 1ns/1ps
module sim_irq_entry_unit;
  logic clk = 0, rst_n = 0;
  logic irq = 0, retire = 0, dop = 0, sf = 0, dpc = 0, we = 0;
  logic [31:0] wd = 0, npc = 0;
  logic redir, flush, lrwe;
  logic [31:0] rpc, lrwd, stat, saved;
  int vecs = 0, bad = 0;

  always #10 clk = ~clk;

  irq_entry_unit u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .retire_i(retire), .next_pc_i(npc),
    .is_dataop_i(dop), .sets_flags_i(sf), .dest_pc_i(dpc), .stat_we_i(we),
    .stat_wd_i(wd), .redirect_o(redir), .redirect_pc_o(rpc), .flush_o(flush),
    .lr_we_o(lrwe), .lr_wd_o(lrwd), .status_o(stat), .saved_o(saved)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic i, input logic rt, input logic ret_op,
                     input logic w, input logic [31:0] d, input logic [31:0] pc);
    irq = i; retire = rt; dop = ret_op; sf = ret_op; dpc = ret_op;
    we = w; wd = d; npc = pc;
    @(posedge clk); @(negedge clk);
    retire = 0; dop = 0; sf = 0; dpc = 0; we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [31:0] st, ent;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 status", stat, 32'h93);
    chk("R1 saved", saved, 0);
    chk("R1 pulses", {29'b0, redir, flush, lrwe}, 0);
    cyc(1, 1, 0, 0, 0, 32'h40);
    chk("R6 masked at reset", {31'b0, redir}, 0);
    chk("R6 masked status", stat, 32'h93);
    for (int f = 0; f < 16; f++) begin
      for (int k = 0; k < 4; k++) begin
        st = {f[3:0], 20'h0, 3'b000, 5'b10000};
        ent = (st & ~32'h1F) | 32'h80 | 32'h12;
        cyc(0, 1, 0, 1, st, 0);
        chk("R9 status write", stat, st);
        cyc(1, 0, 0, 0, 0, 32'h500);
        chk("R6 no retire", {31'b0, redir}, 0);
        chk("R6 no retire status", stat, st);
        cyc(1, 1, 0, 0, 0, 32'h1000 + f * 64 + k * 4);
        chk("R2 redirect", {29'b0, redir, flush, lrwe}, 32'h7);
        chk("R2 vector", rpc, 32'h18);
        chk("R3 link", lrwd, 32'h1004 + f * 64 + k * 4);
        chk("R4 saved", saved, st);
        chk("R5 status", stat, ent);
        cyc(1, 1, 0, 0, 0, 32'h20);
        chk("R2 single pulse / R6 masked", {31'b0, redir}, 0);
        chk("R6 masked status", stat, ent);
        cyc(0, 1, 1, 0, 0, 32'h24);
        chk("R7 restore", stat, st);
        chk("R7 saved kept", saved, st);
        chk("R7 no redirect", {31'b0, redir}, 0);
        chk("R10 round trip", stat[31:28], {28'b0, f[3:0]});
      end
    end
    st = 32'h6000_0010;
    cyc(0, 1, 0, 1, st, 0);
    cyc(1, 1, 0, 0, 0, 32'h300);
    chk("R8 setup entry", {31'b0, redir}, 1);
    cyc(0, 1, 0, 1, 32'h0000_0012, 0);
    chk("R9 write in irq mode", stat, 32'h12);
    cyc(1, 1, 1, 0, 0, 32'h304);
    chk("R8 restore wins", {31'b0, redir}, 0);
    chk("R8 restored", stat, st);
    cyc(1, 1, 0, 0, 0, 32'h308);
    chk("R8 taken next boundary", {31'b0, redir}, 1);
    chk("R8 link", lrwd, 32'h30C);
    chk("R8 saved", saved, st);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule